// File: doc/BRIEF.md
# PLL Rate Table Lookup Engine

This block keeps a constant table of the output rates a PLL supports, with one configuration record per rate. Software or a clock-control sequencer sends it a query and gets back a rate, a record and a hit flag. Three query kinds exist. A rounding query turns a requested frequency into the fastest supported rate that does not exceed it. An exact query fetches the record for one rate and reports a miss if that rate is not in the table. A reverse query takes a record read back from the PLL and names the rate that record produces.

The table is built from parameters. Rates are unsigned 32-bit values in Hz, stored fastest first. The first entry with a zero rate ends the table, and nothing at or after it takes part in any query. The engine walks the table one entry per clock and stops at the first match or at the last live entry.

Queries use a valid/ready handshake. `req_ready` is high only while the engine is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a scan runs, `req_ready` is low and the request pins are ignored, so the sender must hold its request until it is taken. The result comes out as a one-cycle `rsp_valid` pulse with no back-pressure, and the receiver must capture it in that cycle. The engine is idle again during the pulse, so a new request can be taken on the very next edge.

Top module: `pll_rate_lut`

## Requirements
- R1: `req_ready` is high exactly when no scan is running. A request is taken only on an edge with `req_valid` and `req_ready` both high, and request pins that change during a scan have no effect on its result.
- R2: A scan that stops at entry k raises `rsp_valid` k+1 cycles after the edge that took the request. `rsp_valid` stays high for one cycle only.
- R3: A rounding query (`req_op` = 0) returns the first entry whose rate is less than or equal to `req_rate`, with `rsp_hit` = 1.
- R4: A rounding query that finds no live entry at or below `req_rate` returns the last live entry (the slowest rate), its index and its record, with `rsp_hit` = 0.
- R5: An exact query (`req_op` = 1) whose `req_rate` equals a live entry's rate returns that entry's rate, record and index, with `rsp_hit` = 1.
- R6: An exact query with no equal rate returns `rsp_hit` = 0, `rsp_rate` = 0, `rsp_cfg` = 0 and `rsp_idx` = 0 after scanning every live entry.
- R7: A reverse query (`req_op` = 2) matches `req_cfg` against every field of each live record and returns the rate, record and index of the first full match, with `rsp_hit` = 1. Record bits, from most significant to least: [49] DAC enable, [48] DSM enable, [47:24] fractional input, [23:12] integer input, [11:6] reference divider, [5:3] second post divider, [2:0] first post divider.
- R8: A reverse query that matches no live record returns entry 0's rate and record with index 0 and `rsp_hit` = 0.
- R9: The live entry count is the index of the first zero-rate entry. Entries at or after that index are never matched and never scanned.
- R10: `req_op` = 3 behaves exactly like an exact query.
- R11: After reset, `req_ready` = 1 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | Query kind: 0 round, 1 exact, 2 reverse, 3 exact |
| req_rate | input | 32 | Requested rate in Hz (round and exact queries) |
| req_cfg | input | 50 | Record to match (reverse queries) |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Real match found (0 means a fallback value or a miss) |
| rsp_rate | output | 32 | Result rate in Hz |
| rsp_cfg | output | 50 | Result configuration record |
| rsp_idx | output | 3 | Index of the returned entry |

## Verification
The condition hardest to reach from the ports is the end of the live table. Fallbacks, misses and the zero-rate terminator only show up after the full scan length. The bench reaches them with rates below the slowest entry, a zero rate, a rate one hertz off a table value, and records that differ from a live record in a single field. It also uses the record of an entry that sits behind the terminator. The rule that pins are ignored while busy is tested on every query: the bench keeps `req_valid` high during each scan and drives unrelated operands, so a wrongly taken request would corrupt the result that follows.

// File: rtl/pll_rate_pkg.sv
`timescale 1ns/1ps
package pll_rate_pkg;

  typedef struct packed {
    logic        dac_en;
    logic        dsm_en;
    logic [23:0] frac;
    logic [11:0] intg;
    logic [5:0]  rdiv;
    logic [2:0]  pdiv_b;
    logic [2:0]  pdiv_a;
  } pll_cfg_t;

  localparam int CFG_W  = $bits(pll_cfg_t);
  localparam int RATE_W = 32;

  typedef enum logic [1:0] {
    OP_ROUND   = 2'd0,
    OP_EXACT   = 2'd1,
    OP_REVERSE = 2'd2,
    OP_EXACT2  = 2'd3
  } op_e;

  // Rate of table slot idx; slots at or past live hold zero (terminator).
  function automatic logic [RATE_W-1:0] entry_rate(int idx, int live,
                                                   logic [RATE_W-1:0] top_hz,
                                                   logic [RATE_W-1:0] step_hz);
    if (idx < live) return top_hz - step_hz * RATE_W'(idx);
    return '0;
  endfunction

  // Configuration record of table slot idx.
  function automatic pll_cfg_t entry_cfg(int idx);
    pll_cfg_t c;
    c.dac_en = (idx % 2) == 1;
    c.dsm_en = (idx % 3) == 0;
    c.frac   = 24'(32'h00ABC0 + idx * 32'h1357);
    c.intg   = 12'(200 - 12 * idx);
    c.rdiv   = 6'(idx + 1);
    c.pdiv_a = 3'((idx % 7) + 1);
    c.pdiv_b = 3'(((idx + 3) % 7) + 1);
    return c;
  endfunction

endpackage

// File: rtl/pll_rate_rom.sv
`timescale 1ns/1ps
module pll_rate_rom
  import pll_rate_pkg::*;
#(
  parameter int                DEPTH   = 8,
  parameter int                LIVE    = 6,
  parameter logic [RATE_W-1:0] TOP_HZ  = 32'd1_200_000_000,
  parameter logic [RATE_W-1:0] STEP_HZ = 32'd150_000_000,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [IW-1:0]     rd_idx,
  output logic [RATE_W-1:0] rd_rate,
  output pll_cfg_t          rd_cfg,
  output logic [RATE_W-1:0] first_rate,
  output pll_cfg_t          first_cfg,
  output logic [CW-1:0]     live_cnt
);

  logic [RATE_W-1:0] rate_arr [DEPTH];
  pll_cfg_t          cfg_arr  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign rate_arr[g] = entry_rate(g, LIVE, TOP_HZ, STEP_HZ);
    assign cfg_arr[g]  = entry_cfg(g);
  end

  // Live count: position of the first zero rate, or DEPTH if none.
  always_comb begin
    logic found;
    found    = 1'b0;
    live_cnt = CW'(DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && rate_arr[i] == '0) begin
        live_cnt = CW'(i);
        found    = 1'b1;
      end
    end
  end

  assign rd_rate    = rate_arr[rd_idx];
  assign rd_cfg     = cfg_arr[rd_idx];
  assign first_rate = rate_arr[0];
  assign first_cfg  = cfg_arr[0];

endmodule

// File: rtl/pll_rate_match.sv
`timescale 1ns/1ps
module pll_rate_match
  import pll_rate_pkg::*;
(
  input  op_e               op,
  input  logic [RATE_W-1:0] key_rate,
  input  pll_cfg_t          key_cfg,
  input  logic [RATE_W-1:0] ent_rate,
  input  pll_cfg_t          ent_cfg,
  output logic              hit
);

  always_comb begin
    case (op)
      OP_ROUND:   hit = (ent_rate <= key_rate);
      OP_REVERSE: hit = (ent_cfg == key_cfg);
      default:    hit = (ent_rate == key_rate);
    endcase
  end

endmodule

// File: rtl/pll_rate_scan.sv
`timescale 1ns/1ps
module pll_rate_scan
  import pll_rate_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  op_e               req_op,
  input  logic [RATE_W-1:0] req_rate,
  input  pll_cfg_t          req_cfg,
  output op_e               op_q,
  output logic [RATE_W-1:0] key_rate_q,
  output pll_cfg_t          key_cfg_q,
  output logic [IW-1:0]     rd_idx,
  input  logic [RATE_W-1:0] ent_rate,
  input  pll_cfg_t          ent_cfg,
  input  logic [RATE_W-1:0] first_rate,
  input  pll_cfg_t          first_cfg,
  input  logic [CW-1:0]     live_cnt,
  input  logic              ent_hit,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [RATE_W-1:0] rsp_rate,
  output pll_cfg_t          rsp_cfg,
  output logic [IW-1:0]     rsp_idx
);

  logic busy;
  logic at_last;
  logic eff_hit;
  logic is_exact;

  assign req_ready = !busy;
  assign at_last   = (live_cnt == '0) || ((CW'(rd_idx) + CW'(1)) >= live_cnt);
  assign eff_hit   = ent_hit && (live_cnt != '0);
  assign is_exact  = (op_q == OP_EXACT) || (op_q == OP_EXACT2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rd_idx     <= '0;
      op_q       <= OP_ROUND;
      key_rate_q <= '0;
      key_cfg_q  <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_rate   <= '0;
      rsp_cfg    <= '0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy       <= 1'b1;
          rd_idx     <= '0;
          op_q       <= req_op;
          key_rate_q <= req_rate;
          key_cfg_q  <= req_cfg;
        end
      end else if (eff_hit || at_last) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= eff_hit;
        if (eff_hit || op_q == OP_ROUND) begin
          rsp_rate <= ent_rate;
          rsp_cfg  <= ent_cfg;
          rsp_idx  <= rd_idx;
        end else if (is_exact) begin
          rsp_rate <= '0;
          rsp_cfg  <= '0;
          rsp_idx  <= '0;
        end else begin
          rsp_rate <= first_rate;
          rsp_cfg  <= first_cfg;
          rsp_idx  <= '0;
        end
      end else begin
        rd_idx <= rd_idx + IW'(1);
      end
    end
  end

  // R1: a taken request makes the engine busy on the next cycle
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: result is a single-cycle pulse
  p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: a rounding hit never exceeds the request
  p_round_not_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && op_q == OP_ROUND) |-> (rsp_rate <= key_rate_q));

  // R5: an exact hit carries the requested rate
  p_exact_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && is_exact) |-> (rsp_rate == key_rate_q));

  // R6: an exact miss returns zeros
  p_exact_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && is_exact) |-> (rsp_rate == '0 && rsp_cfg == '0));

  // R7: a reverse hit carries the requested record
  p_reverse_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && op_q == OP_REVERSE) |-> (rsp_cfg == key_cfg_q));

  // R8: a reverse miss falls back to entry 0
  p_reverse_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && op_q == OP_REVERSE) |-> (rsp_rate == first_rate));

  // R9: the scan pointer stays inside the live part of the table
  p_idx_in_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && live_cnt != '0) |-> (CW'(rd_idx) < live_cnt));

endmodule

// File: rtl/pll_rate_lut.sv
`timescale 1ns/1ps
module pll_rate_lut
  import pll_rate_pkg::*;
#(
  parameter int                DEPTH   = 8,
  parameter int                LIVE    = 6,
  parameter logic [RATE_W-1:0] TOP_HZ  = 32'd1_200_000_000,
  parameter logic [RATE_W-1:0] STEP_HZ = 32'd150_000_000,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [CFG_W-1:0]  req_cfg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [RATE_W-1:0] rsp_rate,
  output logic [CFG_W-1:0]  rsp_cfg,
  output logic [IW-1:0]     rsp_idx
);

  op_e               op_q;
  logic [RATE_W-1:0] key_rate_q;
  pll_cfg_t          key_cfg_q;
  logic [IW-1:0]     rd_idx;
  logic [RATE_W-1:0] ent_rate;
  pll_cfg_t          ent_cfg;
  logic [RATE_W-1:0] first_rate;
  pll_cfg_t          first_cfg;
  logic [CW-1:0]     live_cnt;
  logic              ent_hit;
  pll_cfg_t          rsp_cfg_s;

  pll_rate_rom #(
    .DEPTH(DEPTH), .LIVE(LIVE), .TOP_HZ(TOP_HZ), .STEP_HZ(STEP_HZ)
  ) u_rom (
    .rd_idx    (rd_idx),
    .rd_rate   (ent_rate),
    .rd_cfg    (ent_cfg),
    .first_rate(first_rate),
    .first_cfg (first_cfg),
    .live_cnt  (live_cnt)
  );

  pll_rate_match u_match (
    .op      (op_q),
    .key_rate(key_rate_q),
    .key_cfg (key_cfg_q),
    .ent_rate(ent_rate),
    .ent_cfg (ent_cfg),
    .hit     (ent_hit)
  );

  pll_rate_scan #(.DEPTH(DEPTH)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (op_e'(req_op)),
    .req_rate  (req_rate),
    .req_cfg   (pll_cfg_t'(req_cfg)),
    .op_q      (op_q),
    .key_rate_q(key_rate_q),
    .key_cfg_q (key_cfg_q),
    .rd_idx    (rd_idx),
    .ent_rate  (ent_rate),
    .ent_cfg   (ent_cfg),
    .first_rate(first_rate),
    .first_cfg (first_cfg),
    .live_cnt  (live_cnt),
    .ent_hit   (ent_hit),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_rate  (rsp_rate),
    .rsp_cfg   (rsp_cfg_s),
    .rsp_idx   (rsp_idx)
  );

  assign rsp_cfg = rsp_cfg_s;

endmodule

// File: tb/pll_rate_lut_tb.sv
`timescale 1ns/1ps
module pll_rate_lut_tb;
  import pll_rate_pkg::*;

  localparam int                DEPTH   = 8;
  localparam int                LIVE    = 6;
  localparam logic [31:0]       TOP_HZ  = 32'd1_200_000_000;
  localparam logic [31:0]       STEP_HZ = 32'd150_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_rate = '0;
  logic [49:0] req_cfg = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_rate;
  logic [49:0] rsp_cfg;
  logic [2:0]  rsp_idx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pll_rate_lut #(.DEPTH(DEPTH), .LIVE(LIVE), .TOP_HZ(TOP_HZ), .STEP_HZ(STEP_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rate(req_rate), .req_cfg(req_cfg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rate(rsp_rate),
    .rsp_cfg(rsp_cfg), .rsp_idx(rsp_idx)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: returns scan length and the expected result.
  task automatic model(input int op, input logic [31:0] rate, input logic [49:0] cfg,
                       output int lat, output bit hit, output logic [31:0] e_rate,
                       output logic [49:0] e_cfg, output int e_idx);
    int live;
    int stop;
    live = DEPTH;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (entry_rate(i, LIVE, TOP_HZ, STEP_HZ) == 0) live = i;
    stop = -1;
    for (int i = 0; i < live; i++) begin
      bit m;
      if (op == 0)      m = entry_rate(i, LIVE, TOP_HZ, STEP_HZ) <= rate;
      else if (op == 2) m = 50'(entry_cfg(i)) == cfg;
      else              m = entry_rate(i, LIVE, TOP_HZ, STEP_HZ) == rate;
      if (m && stop < 0) stop = i;
    end
    hit = stop >= 0;
    lat = hit ? stop + 1 : live;
    if (hit) begin
      e_idx = stop;
    end else if (op == 0) begin
      e_idx = live - 1;
    end else begin
      e_idx = 0;
    end
    if (!hit && (op == 1 || op == 3)) begin
      e_rate = '0;
      e_cfg  = '0;
    end else begin
      e_rate = entry_rate(e_idx, LIVE, TOP_HZ, STEP_HZ);
      e_cfg  = 50'(entry_cfg(e_idx));
    end
  endtask

  // Drive one query at a negedge, keep junk on the request pins while busy,
  // and compare the ports against the model on every cycle.
  task automatic query(input string tag, input int op, input logic [31:0] rate,
                       input logic [49:0] cfg);
    int lat; bit hit; logic [31:0] e_rate; logic [49:0] e_cfg; int e_idx;
    model(op, rate, cfg, lat, hit, e_rate, e_cfg, e_idx);
    chk(req_ready == 1'b1, {tag, " R1 ready when idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_rate  = rate;
    req_cfg   = cfg;
    @(negedge clk);
    req_op   = ~req_op;
    req_rate = ~rate;
    req_cfg  = ~cfg;
    for (int c = 1; c <= lat; c++) begin
      chk(rsp_valid == 1'b0, {tag, " R2 no early result"}, 64'(rsp_valid), 64'd0);
      chk(req_ready == 1'b0, {tag, " R1 busy holds off"}, 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R2 result timing"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == hit, {tag, " hit"}, 64'(rsp_hit), 64'(hit));
    chk(rsp_rate == e_rate, {tag, " rate"}, 64'(rsp_rate), 64'(e_rate));
    chk(rsp_cfg == e_cfg, {tag, " cfg"}, 64'(rsp_cfg), 64'(e_cfg));
    chk(32'(rsp_idx) == e_idx, {tag, " idx"}, 64'(rsp_idx), 64'(e_idx));
    chk(req_ready == 1'b1, {tag, " R1 idle with result"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " R2 single pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [49:0] c3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R11 reset valid", 64'(rsp_valid), 64'd0);

    query("R3 above maximum",   0, 32'd2_000_000_000, '0);
    query("R3 on an entry",     0, 32'd900_000_000,   '0);
    query("R3 between entries", 0, 32'd800_000_000,   '0);
    query("R4 below minimum",   0, 32'd100_000_000,   '0);
    query("R4 zero request",    0, 32'd0,             '0);
    query("R5 exact hit",       1, 32'd600_000_000,   '0);
    query("R5 exact first",     1, 32'd1_200_000_000, '0);
    query("R6 exact off by one",1, 32'd600_000_001,   '0);
    query("R9 exact zero rate", 1, 32'd0,             '0);
    query("R10 op3 exact",      3, 32'd1_050_000_000, '0);
    query("R10 op3 miss",       3, 32'd1_050_000_001, '0);
    query("R7 reverse entry3",  2, '0, 50'(entry_cfg(3)));
    query("R7 reverse entry0",  2, '0, 50'(entry_cfg(0)));
    query("R7 reverse last",    2, '0, 50'(entry_cfg(5)));
    c3 = 50'(entry_cfg(3)) ^ 50'h1;
    query("R8 reverse postdiv off", 2, '0, c3);
    c3 = 50'(entry_cfg(5)) ^ (50'h1 << 30);
    query("R8 reverse frac off",    2, '0, c3);
    c3 = 50'(entry_cfg(5)) ^ (50'h1 << 49);
    query("R8 reverse dac off",     2, '0, c3);
    query("R9 reverse past end",    2, '0, 50'(entry_cfg(6)));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule